// File: doc/BRIEF.md
# Spindle Motor Drive Output Modulator

This block turns a signed drive demand from a digital spindle speed servo into the logic levels on two motor driver pins, `drv_a` and `drv_b`. A two-bit configuration input selects how the demand is encoded. In the pulse-density modes the demand goes to a first-order accumulator. The accumulator carry forms a bit stream whose density is 50% when the demand is zero. A higher density accelerates the motor and a lower density brakes it. That stream appears on `drv_a` alone or, in the two-line variant, on `drv_a` with its complement on `drv_b`. In PWM mode, accelerating demand is encoded as a pulse width on `drv_a` and braking demand as a pulse width on `drv_b`. The PWM frame is 256 modulator ticks long.

Every state change happens only in a cycle where the modulator clock enable `tick` is high. A servo loop elsewhere writes `demand` and the mode. When tachometer control is active the complementary pulse-density mode is not allowed, so that setting falls back to the one-line mode. The reserved mode code also falls back to the one-line mode.

Top module: `spindle_drive_mod`

## Requirements
- R1: While `rst_n` is low and after it is released, before any tick, both `drv_a` and `drv_b` are low. The accumulator and the PWM tick counter start at zero.
- R2: `drv_a` and `drv_b` change only on the clock edge that samples `tick` high. In every other cycle they hold their value.
- R3: In a pulse-density mode, with `demand` held at signed value d (two's complement, DW=8) over any 256 consecutive ticks, `drv_a` is high after exactly d+128 of those ticks. The accumulator adds the demand with its sign bit inverted, and its carry out is the output bit.
- R4: In one-line pulse-density mode (`mode` = 2'b00), `drv_b` is low after every tick.
- R5: In two-line pulse-density mode (`mode` = 2'b01) with `tacho_en` low, `drv_b` is the inverse of `drv_a` after every tick.
- R6: With `mode` = 2'b01 and `tacho_en` high, the block behaves exactly as in mode 2'b00.
- R7: In PWM mode (`mode` = 2'b10), with a positive demand d, `drv_a` is high after the first d ticks of each 256-tick period and `drv_b` stays low.
- R8: In PWM mode with a negative demand d, `drv_b` is high after the first |d| ticks of each period and `drv_a` stays low. A zero demand keeps both pins low, and the two pins are never high together.
- R9: In PWM mode the demand is captured on the tick at which the period counter is zero. A demand change later in the period has no effect until the next period begins.
- R10: The reserved code `mode` = 2'b11 behaves exactly as mode 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Modulator clock enable, one cycle per modulator step |
| demand | input | 8 | Signed drive demand, positive accelerates |
| mode | input | 2 | Output mode: 00 one-line PD, 01 two-line PD, 10 PWM, 11 reserved |
| tacho_en | input | 1 | Tachometer control active, which forbids two-line PD |
| drv_a | output | 1 | Accelerate / pulse-density drive pin |
| drv_b | output | 1 | Brake / complement drive pin |

## Verification
Each stimulus vector holds one demand for a full 256-tick window and counts the highs on both pins. In pulse-density modes, demands of zero, midscale positive, full-scale positive and full-scale negative separate the 50% centre and the sign-bit offset from a plain unsigned or inverted accumulation. In PWM mode, positive, negative, zero and extreme demands separate the accelerate pin from the brake pin and show a -128 magnitude of 128. The tachometer override and the reserved code are checked with demands that give a distinct complement count if the fallback is missing. A demand change part-way through a PWM period shows whether the demand is captured only at the period start.

// File: rtl/spdm_pkg.sv
package spdm_pkg;
    typedef enum logic [1:0] {
        MD_PD1 = 2'b00,
        MD_PD2 = 2'b01,
        MD_PWM = 2'b10,
        MD_RSV = 2'b11
    } drv_mode_e;

    typedef struct packed {
        logic a;
        logic b;
    } drv_pins_t;
endpackage

// File: rtl/spdm_sigma.sv
// First-order accumulator: carry of (acc + offset-binary demand) is the stream bit.
module spdm_sigma #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] demand,
    output logic          pd_bit
);
    logic [DW-1:0] acc_d, acc_q;
    logic [DW-1:0] offs;
    logic [DW:0]   sum;

    always_comb begin
        offs   = {~demand[DW-1], demand[DW-2:0]};
        sum    = {1'b0, acc_q} + {1'b0, offs};
        pd_bit = sum[DW];
        acc_d  = tick ? sum[DW-1:0] : acc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/spdm_pwm.sv
// Split accelerate/brake PWM with a 2**DW tick frame; demand latched at frame start.
module spdm_pwm #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] demand,
    output logic          acc_bit,
    output logic          brk_bit
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] dem;
    } pwm_st_t;

    pwm_st_t       st_d, st_q;
    logic [DW-1:0] sample;
    logic [DW-1:0] acc_mag;
    logic [DW-1:0] brk_mag;
    logic          at_start;

    always_comb begin
        at_start = (st_q.cnt == '0);
        sample   = at_start ? demand : st_q.dem;
        acc_mag  = (!sample[DW-1]) ? sample : '0;
        brk_mag  = sample[DW-1] ? (DW'(0) - sample) : '0;
        acc_bit  = (st_q.cnt < acc_mag);
        brk_bit  = (st_q.cnt < brk_mag);
        st_d     = st_q;
        if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (at_start) st_d.dem = demand;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spindle_drive_mod.sv
module spindle_drive_mod #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [DW-1:0] demand,
    input  logic [1:0]    mode,
    input  logic          tacho_en,
    output logic          drv_a,
    output logic          drv_b
);
    import spdm_pkg::*;

    logic      pd_bit, acc_bit, brk_bit;
    drv_mode_e eff_mode;
    drv_pins_t out_d, out_q;

    spdm_sigma #(.DW(DW)) u_sigma (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .demand (demand),
        .pd_bit (pd_bit)
    );

    spdm_pwm #(.DW(DW)) u_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .demand  (demand),
        .acc_bit (acc_bit),
        .brk_bit (brk_bit)
    );

    always_comb begin
        eff_mode = drv_mode_e'(mode);
        if (eff_mode == MD_RSV)                eff_mode = MD_PD1;
        if (eff_mode == MD_PD2 && tacho_en)    eff_mode = MD_PD1;

        out_d = out_q;
        if (tick) begin
            unique case (eff_mode)
                MD_PD2:  out_d = '{a: pd_bit,  b: ~pd_bit};
                MD_PWM:  out_d = '{a: acc_bit, b: brk_bit};
                default: out_d = '{a: pd_bit,  b: 1'b0};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign drv_a = out_q.a;
    assign drv_b = out_q.b;
endmodule

// File: rtl/spdm_checker.sv
module spdm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [1:0] mode,
    input logic       tacho_en,
    input logic       drv_a,
    input logic       drv_b
);
    // R2
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(drv_a) && $stable(drv_b)));

    // R4, R10
    a_r4_one_line_b_low: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (mode == 2'b00 || mode == 2'b11)) |=> !drv_b);

    // R5
    a_r5_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == 2'b01 && !tacho_en) |=> (drv_b != drv_a));

    // R6
    a_r6_tacho_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == 2'b01 && tacho_en) |=> !drv_b);

    // R8
    a_r8_pwm_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == 2'b10) |=> !(drv_a && drv_b));
endmodule

bind spindle_drive_mod spdm_checker u_spdm_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode     (mode),
    .tacho_en (tacho_en),
    .drv_a    (drv_a),
    .drv_b    (drv_b)
);

// File: tb/tb_spindle_drive_mod.sv
`timescale 1ns/1ps
module tb_spindle_drive_mod;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] demand = 8'd0;
    logic [1:0] mode = 2'b00;
    logic       tacho_en = 1'b0;
    logic       drv_a, drv_b;

    int checks = 0;
    int errors = 0;
    int cnt_a, cnt_b, inv_bad, hold_bad;

    always #2.5 clk = ~clk;

    spindle_drive_mod dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .demand(demand),
        .mode(mode), .tacho_en(tacho_en), .drv_a(drv_a), .drv_b(drv_b)
    );

    localparam int NV = 11;
    localparam logic [1:0] V_MODE [NV] = '{2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 2'b01,
                                           2'b10, 2'b10, 2'b10, 2'b10, 2'b11};
    localparam bit V_TACHO [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0};
    localparam int V_DEM [NV] = '{0, 64, -128, 127, -32, 50, 100, -128, 0, 127, 10};
    localparam int V_A [NV]   = '{128, 192, 0, 255, 96, 178, 100, 0, 0, 127, 138};
    localparam int V_B [NV]   = '{0, 0, 0, 0, 160, 0, 0, 128, 0, 0, 0};
    string v_tag [NV] = '{"R3 R4", "R3 R4", "R3 R4", "R3 R4", "R3 R5", "R6",
                          "R7", "R8", "R8", "R7", "R10"};

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Starts and ends at a negedge; one tick cycle followed by one idle cycle.
    task automatic one_tick();
        logic pa, pb;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        pa = drv_a; pb = drv_b;
        if (pa) cnt_a++;
        if (pb) cnt_b++;
        if (pb == pa) inv_bad++;
        @(negedge clk);
        if (drv_a != pa || drv_b != pb) hold_bad++;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) one_tick();
    endtask

    task automatic clear_counts();
        cnt_a = 0; cnt_b = 0; inv_bad = 0; hold_bad = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 drv_a in reset", int'(drv_a), 0);
        check("R1 drv_b in reset", int'(drv_b), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 drv_a after reset", int'(drv_a), 0);
        check("R1 drv_b after reset", int'(drv_b), 0);

        // Table walk: each vector is one aligned 256-tick window.
        for (int v = 0; v < NV; v++) begin
            mode = V_MODE[v];
            tacho_en = V_TACHO[v];
            demand = 8'(V_DEM[v]);
            clear_counts();
            run_ticks(256);
            check({v_tag[v], " drv_a high count"}, cnt_a, V_A[v]);
            check({v_tag[v], " drv_b high count"}, cnt_b, V_B[v]);
            if (V_MODE[v] == 2'b01 && !V_TACHO[v])
                check("R5 complement mismatches", inv_bad, 0);
            check("R2 output moved without tick", hold_bad, 0);
        end

        // R9: mid-period demand change is ignored until the next period.
        mode = 2'b10; tacho_en = 1'b0;
        demand = 8'(40);
        clear_counts();
        run_ticks(100);
        demand = 8'(-90);
        run_ticks(156);
        check("R9 drv_a count with late change", cnt_a, 40);
        check("R9 drv_b count with late change", cnt_b, 0);
        clear_counts();
        run_ticks(256);
        check("R9 drv_b count next period", cnt_b, 90);
        check("R9 drv_a count next period", cnt_a, 0);

        // R2: long idle with tick low, pins hold.
        begin
            logic ha, hb;
            ha = drv_a; hb = drv_b;
            demand = 8'(127); mode = 2'b01;
            repeat (20) @(negedge clk);
            check("R2 drv_a held idle", int'(drv_a), int'(ha));
            check("R2 drv_b held idle", int'(drv_b), int'(hb));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule